// File: doc/BRIEF.md
# Serial Transmitter with Counted Break Sequence

This block turns parallel characters into an asynchronous serial bit stream. Each bit lasts one period of an external bit-rate strobe. The frame is programmable: 5 to 14 data bits, an optional even or odd parity bit, and one or two stop bits. While the transmitter is enabled and no character is offered, it sends idle characters, which are all ones for one full character length. A character is offered with a valid/take handshake. The source holds the data until the block takes it at a character boundary, so characters offered back to back leave no gap on the line.

A stop command ends normal operation. The block first finishes the character in progress. It then sends a programmed number of break characters. Each break character holds the line low for exactly one full character length of the current framing. When the last break character ends, the line returns high and a done flag rises. The block accepts no data until the enable input is taken low and raised again.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd` is 1, `brk_done` is 0 and `tx_take` is 0.
- R2: While `en` is 0 and the block is not in a break sequence, `txd` stays 1. While `en` is 1 and `tx_valid` is 0, the block sends idle characters, so `txd` stays 1.
- R3: A data character is sent LSB first and, for an effective data length D, it has length L = 2 + D + P + S, where P is the parity enable and S is `two_stop`. The line carries, in time order: one 0 start bit, D data bits, then (when `par_en` is 1) a parity bit, then 1 or 2 stop bits at 1. The parity bit is the XOR of the D data bits when `par_odd` is 0, and its inverse when `par_odd` is 1. Each bit lasts one `bit_tick` period.
- R4: A `data_len` below 5 acts as 5 and a `data_len` above `DATA_W_MAX` acts as `DATA_W_MAX`. Bits of `tx_data` at or above the effective length never reach the line.
- R5: `tx_take` is high for one clock, in the strobe cycle that starts a character, when the block is running and `tx_valid` is 1. That character's start bit appears on `txd` from the next clock. When a new character is valid at the next boundary, its start bit directly follows the previous stop bit.
- R6: A one-clock `stop_cmd` pulse while running lets the current character finish. The block then sends `brk_count` break characters back to back. Each break character is all zeros for L bits of the current framing, so `txd` is low for exactly `brk_count`·L consecutive bits.
- R7: With `brk_count` equal to 0, a stop command sends no zero bits, and `brk_done` rises at the next character boundary.
- R8: After the break sequence, `txd` is 1 and `brk_done` is 1. `tx_valid` is then ignored (no `tx_take`, line stays high) for as long as `en` stays 1. Dropping `en` clears `brk_done`, and raising `en` again resumes idle and data transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-clock strobe per serial bit period |
| en | input | 1 | Transmitter enable |
| stop_cmd | input | 1 | One-clock request to stop and send the break sequence |
| brk_count | input | BRK_CNT_W | Number of break characters to send |
| data_len | input | 4 | Data bits per character (clamped to 5..DATA_W_MAX) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_data | input | DATA_W_MAX | Character to send, LSB first |
| tx_valid | input | 1 | `tx_data` holds a character to send |
| tx_take | output | 1 | Character accepted in this cycle |
| txd | output | 1 | Serial line |
| brk_done | output | 1 | Break sequence complete; transmitter halted |

## Verification
The bench builds the block with `DATA_W_MAX` at 14, parity support enabled and an 8-bit `brk_count`. This gives frames from 7 bits (5N1) up to the widest 18-bit frame (14 data bits, parity, 2 stop bits). With these values, clamping at both ends of the data length can be checked, and break runs can be measured against several different frame lengths. A free-running divide-by-four strobe stretches every bit over four clocks. The line is logged once per bit, so whole frames, zero-run lengths and the absence of gaps between back-to-back characters are compared bit by bit against frames the bench builds itself.

// File: rtl/uart_brk_pkg.sv
`timescale 1ns/1ps
package uart_brk_pkg;
   typedef enum logic [1:0] {TXM_OFF, TXM_RUN, TXM_BRK, TXM_HALT} txm_e;
   typedef enum logic [1:0] {CH_IDLE, CH_DATA, CH_BREAK} ch_kind_e;
   localparam int unsigned DATA_W_FLOOR = 5;
   localparam int unsigned DATA_W_CEIL  = 14;
endpackage

// File: rtl/uart_brk_frame.sv
`timescale 1ns/1ps
module uart_brk_frame
   import uart_brk_pkg::*;
#(
   parameter int unsigned DATA_W_MAX = 14,
   parameter bit          HAS_PARITY = 1'b1,
   parameter int unsigned FRAME_W    = DATA_W_MAX + 4,
   parameter int unsigned LEN_W      = $clog2(FRAME_W + 1)
) (
   input  ch_kind_e              kind,
   input  logic [DATA_W_MAX-1:0] data,
   input  logic [3:0]            data_len,
   input  logic                  par_en,
   input  logic                  par_odd,
   input  logic                  two_stop,
   output logic [FRAME_W-1:0]    frame,
   output logic [LEN_W-1:0]      flen
);
   logic [LEN_W-1:0]      eff_len;
   logic [DATA_W_MAX-1:0] keep;
   logic                  par_use;
   logic                  par_bit;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_use = par_en;
      end else begin : g_nopar
         assign par_use = 1'b0;
      end
   endgenerate

   always_comb begin
      if (data_len < 4'(DATA_W_FLOOR))
         eff_len = LEN_W'(DATA_W_FLOOR);
      else if (data_len > 4'(DATA_W_MAX))
         eff_len = LEN_W'(DATA_W_MAX);
      else
         eff_len = LEN_W'(data_len);
   end

   always_comb begin
      for (int i = 0; i < int'(DATA_W_MAX); i++)
         keep[i] = (LEN_W'(i) < eff_len);
      par_bit = (^(data & keep)) ^ par_odd;
   end

   always_comb begin
      frame = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < int'(DATA_W_MAX); i++)
         if (keep[i]) frame[i+1] = data[i];
      if (par_use) frame[int'(eff_len)+1] = par_bit;
      if (kind == CH_IDLE)  frame = '1;
      if (kind == CH_BREAK) frame = '0;
      flen = LEN_W'(2) + eff_len + LEN_W'(par_use) + LEN_W'(two_stop);
   end
endmodule

// File: rtl/uart_brk_shift.sv
`timescale 1ns/1ps
module uart_brk_shift #(
   parameter int unsigned FRAME_W = 18,
   parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [LEN_W-1:0]   flen,
   output logic               line,
   output logic               at_edge
);
   logic [FRAME_W-1:0] sh_q;
   logic [LEN_W-1:0]   left_q;

   assign at_edge = (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line   <= 1'b1;
         sh_q   <= '0;
         left_q <= '0;
      end else if (bit_tick) begin
         if (left_q == '0) begin
            if (load) begin
               line   <= frame[0];
               sh_q   <= {1'b0, frame[FRAME_W-1:1]};
               left_q <= flen - LEN_W'(1);
            end else begin
               line <= 1'b1;
            end
         end else begin
            line   <= sh_q[0];
            sh_q   <= {1'b0, sh_q[FRAME_W-1:1]};
            left_q <= left_q - LEN_W'(1);
         end
      end
   end

   // R3
   left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q < LEN_W'(FRAME_W));
endmodule

// File: rtl/uart_brk_seq.sv
`timescale 1ns/1ps
module uart_brk_seq
   import uart_brk_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             at_edge,
   input  logic             en,
   input  logic             stop_cmd,
   input  logic [CNT_W-1:0] brk_count,
   input  logic             tx_valid,
   input  logic             line,
   output ch_kind_e         kind,
   output logic             load,
   output logic             take,
   output logic             done
);
   txm_e             mode_q, mode_d;
   logic             stop_pend_q;
   logic [CNT_W-1:0] brk_left_q;
   logic             edge_go, stop_now;
   logic [CNT_W-1:0] left_src;

   assign edge_go  = bit_tick & at_edge;
   assign stop_now = stop_pend_q | stop_cmd;
   assign left_src = stop_pend_q ? brk_left_q : brk_count;
   assign done     = (mode_q == TXM_HALT);

   always_comb begin
      mode_d = mode_q;
      load   = 1'b0;
      take   = 1'b0;
      kind   = CH_IDLE;
      unique case (mode_q)
         TXM_OFF:  if (en) mode_d = TXM_RUN;
         TXM_RUN: begin
            if (edge_go) begin
               if (stop_now) begin
                  if (left_src == '0) begin
                     mode_d = TXM_HALT;
                  end else begin
                     mode_d = TXM_BRK;
                     load   = 1'b1;
                     kind   = CH_BREAK;
                  end
               end else if (!en) begin
                  mode_d = TXM_OFF;
               end else begin
                  load = 1'b1;
                  if (tx_valid) begin
                     kind = CH_DATA;
                     take = 1'b1;
                  end
               end
            end
         end
         TXM_BRK: begin
            if (edge_go) begin
               if (brk_left_q == '0) begin
                  mode_d = TXM_HALT;
               end else begin
                  load = 1'b1;
                  kind = CH_BREAK;
               end
            end
         end
         TXM_HALT: if (!en) mode_d = TXM_OFF;
         default:  mode_d = TXM_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q      <= TXM_OFF;
         stop_pend_q <= 1'b0;
         brk_left_q  <= '0;
      end else begin
         mode_q <= mode_d;
         if (mode_q == TXM_RUN && edge_go && stop_now) begin
            stop_pend_q <= 1'b0;
            brk_left_q  <= (left_src != '0) ? left_src - CNT_W'(1) : '0;
         end else if (mode_q == TXM_RUN && stop_cmd && !stop_pend_q) begin
            stop_pend_q <= 1'b1;
            brk_left_q  <= brk_count;
         end else if (mode_q == TXM_BRK && edge_go && brk_left_q != '0) begin
            brk_left_q <= brk_left_q - CNT_W'(1);
         end
      end
   end

   // R2
   off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TXM_OFF) |-> line);
   // R6
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TXM_BRK) |-> !line);
   // R6
   brk_left_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TXM_BRK) |=> (brk_left_q <= $past(brk_left_q)));
endmodule

// File: rtl/uart_brk_tx.sv
`timescale 1ns/1ps
module uart_brk_tx
   import uart_brk_pkg::*;
#(
   parameter int unsigned DATA_W_MAX = 14,
   parameter int unsigned BRK_CNT_W  = 16,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_tick,
   input  logic                  en,
   input  logic                  stop_cmd,
   input  logic [BRK_CNT_W-1:0]  brk_count,
   input  logic [3:0]            data_len,
   input  logic                  par_en,
   input  logic                  par_odd,
   input  logic                  two_stop,
   input  logic [DATA_W_MAX-1:0] tx_data,
   input  logic                  tx_valid,
   output logic                  tx_take,
   output logic                  txd,
   output logic                  brk_done
);
   localparam int unsigned FRAME_W = DATA_W_MAX + 4;
   localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W_MAX < DATA_W_FLOOR || DATA_W_MAX > DATA_W_CEIL) begin : g_bad_width
         $error("uart_brk_tx: DATA_W_MAX must lie in 5..14");
      end
      if (BRK_CNT_W < 1) begin : g_bad_cnt
         $error("uart_brk_tx: BRK_CNT_W must be at least 1");
      end
   endgenerate

   ch_kind_e             kind;
   logic                 load, at_edge;
   logic [FRAME_W-1:0]   frame;
   logic [LEN_W-1:0]     flen;

   uart_brk_frame #(
      .DATA_W_MAX (DATA_W_MAX),
      .HAS_PARITY (HAS_PARITY),
      .FRAME_W    (FRAME_W),
      .LEN_W      (LEN_W)
   ) u_frame (
      .kind     (kind),
      .data     (tx_data),
      .data_len (data_len),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .two_stop (two_stop),
      .frame    (frame),
      .flen     (flen)
   );

   uart_brk_shift #(
      .FRAME_W (FRAME_W),
      .LEN_W   (LEN_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .load     (load),
      .frame    (frame),
      .flen     (flen),
      .line     (txd),
      .at_edge  (at_edge)
   );

   uart_brk_seq #(
      .CNT_W (BRK_CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .at_edge   (at_edge),
      .en        (en),
      .stop_cmd  (stop_cmd),
      .brk_count (brk_count),
      .tx_valid  (tx_valid),
      .line      (txd),
      .kind      (kind),
      .load      (load),
      .take      (tx_take),
      .done      (brk_done)
   );

   // R5
   take_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> !txd);
   // R8
   done_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |-> txd);
endmodule

// File: tb/uart_brk_tx_bench.sv
`timescale 1ns/1ps
module uart_brk_tx_bench;
   localparam int DW = 14;
   localparam int CW = 8;
   localparam int LOGN = 16384;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick;
   logic          en = 1'b0, stop_cmd = 1'b0;
   logic [CW-1:0] brk_count = '0;
   logic [3:0]    data_len = 4'd8;
   logic          par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          tx_valid = 1'b0;
   logic          tx_take, txd, brk_done;

   int tests = 0, fails = 0;
   logic [1:0] div = '0;
   logic bitlog [0:LOGN-1];
   int nb = 0, takes = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) div <= '0;
      else div <= div + 2'd1;
   end
   assign bit_tick = (div == 2'd3);

   always @(negedge clk) begin
      if (rst_n && bit_tick) begin
         if (nb < LOGN) begin
            bitlog[nb] = txd;
            nb++;
         end
         if (tx_take) takes++;
      end
   end

   uart_brk_tx #(.DATA_W_MAX(DW), .BRK_CNT_W(CW), .HAS_PARITY(1'b1)) u_uart_brk_tx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .en(en), .stop_cmd(stop_cmd),
      .brk_count(brk_count), .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
      .two_stop(two_stop), .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
      .txd(txd), .brk_done(brk_done));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int clampd(input int d);
      if (d < 5) return 5;
      if (d > DW) return DW;
      return d;
   endfunction

   function automatic logic [18:0] mk_frame(input int de, input bit pe, input bit po,
                                            input logic [DW-1:0] d);
      logic [18:0] f = '1;
      logic p = po;
      f[0] = 1'b0;
      for (int i = 0; i < de; i++) begin
         f[1+i] = d[i];
         p ^= d[i];
      end
      if (pe) f[1+de] = p;
      return f;
   endfunction

   function automatic int find_zero(input int from);
      for (int i = from; i < nb; i++) if (bitlog[i] == 1'b0) return i;
      return -1;
   endfunction

   task automatic wait_bits(input int base, input int n);
      while (nb < base + n) @(posedge clk);
   endtask

   task automatic wait_take(input string req);
      int t0 = takes;
      for (int k = 0; k < 2000 && takes == t0; k++) @(posedge clk);
      check(takes == t0 + 1, req, "tx_take count", takes - t0, 1);
   endtask

   task automatic chk_frame(input int s, input int nbits, input logic [18:0] ex,
                            input string req, input string what);
      logic [18:0] act = '1;
      logic [18:0] exm = '1;
      if (s < 0) begin
         check(1'b0, req, {what, " start bit missing"}, -1, 0);
         return;
      end
      for (int i = 0; i < nbits; i++) begin
         act[i] = bitlog[s+i];
         exm[i] = ex[i];
      end
      check(act == exm, req, what, int'(act), int'(exm));
   endtask

   task automatic t_reset();
      // R1
      check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
      check(brk_done === 1'b0, "R1", "brk_done after reset", int'(brk_done), 0);
      check(tx_take === 1'b0, "R1", "tx_take after reset", int'(tx_take), 0);
   endtask

   task automatic t_idle();
      int base = nb, z = 0, t0 = takes;
      wait_bits(base, 20);
      @(negedge clk) en = 1'b1;
      wait_bits(base, 60);
      for (int i = base; i < nb; i++) if (!bitlog[i]) z++;
      // R2
      check(z == 0, "R2", "zero bits while disabled/idle", z, 0);
      check(takes == t0, "R2", "takes while idle", takes - t0, 0);
   endtask

   task automatic t_char(input int dl, input bit pe, input bit po, input bit ts,
                         input logic [DW-1:0] d, input string req);
      int base, de, L;
      @(negedge clk);
      data_len = 4'(dl); par_en = pe; par_odd = po; two_stop = ts; tx_data = d;
      base = nb; tx_valid = 1'b1;
      wait_take(req);
      @(negedge clk) tx_valid = 1'b0;
      de = clampd(dl); L = 2 + de + int'(pe) + int'(ts);
      wait_bits(base, 3 * L + 2);
      chk_frame(find_zero(base), L + 1, mk_frame(de, pe, po, d), req, "data frame");
   endtask

   task automatic t_b2b();
      int base, L = 10, s;
      @(negedge clk);
      data_len = 4'd8; par_en = 1'b0; two_stop = 1'b0;
      base = nb; tx_data = 14'h0081; tx_valid = 1'b1;
      wait_take("R5");
      @(negedge clk) tx_data = 14'h007E;
      wait_take("R5");
      @(negedge clk) tx_valid = 1'b0;
      wait_bits(base, 4 * L);
      s = find_zero(base);
      // R5: second start bit right after first stop bit
      chk_frame(s, L, mk_frame(8, 1'b0, 1'b0, 14'h0081), "R5", "first frame");
      chk_frame(s + L, L + 1, mk_frame(8, 1'b0, 1'b0, 14'h007E), "R5", "second frame");
   endtask

   task automatic t_break(input int dl, input bit pe, input bit ts, input int cnt,
                          input bit probe_halt);
      int base, L, z = 0, s, r = 0, mark, t0;
      string req = (cnt == 0) ? "R7" : "R6";
      @(negedge clk);
      data_len = 4'(dl); par_en = pe; two_stop = ts; brk_count = CW'(cnt); tx_valid = 1'b0;
      L = 2 + clampd(dl) + int'(pe) + int'(ts);
      base = nb;
      wait_bits(base, L + 3);
      @(negedge clk) stop_cmd = 1'b1;
      @(negedge clk) stop_cmd = 1'b0;
      for (int k = 0; k < (cnt + 3) * L * 4 + 100 && !brk_done; k++) @(posedge clk);
      mark = nb;
      wait_bits(mark, 2 * L);
      for (int i = base; i < nb; i++) if (!bitlog[i]) z++;
      check(z == cnt * L, req, "break zero bits", z, cnt * L);
      if (cnt > 0) begin
         s = find_zero(base);
         while (s >= 0 && s + r < nb && !bitlog[s+r]) r++;
         check(r == z, "R6", "break run contiguous", r, z);
      end
      @(negedge clk);
      check(brk_done === 1'b1 && txd === 1'b1, "R8", "halted line high, done",
            int'({brk_done, txd}), 3);
      if (probe_halt) begin
         t0 = takes; mark = nb; tx_valid = 1'b1; tx_data = 14'h0000;
         wait_bits(mark, 3 * L);
         z = 0;
         for (int i = mark; i < nb; i++) if (!bitlog[i]) z++;
         // R8: data ignored while halted
         check(takes == t0 && z == 0, "R8", "takes/zeros while halted", takes - t0 + z, 0);
         check(brk_done === 1'b1, "R8", "done held while en high", int'(brk_done), 1);
         @(negedge clk) tx_valid = 1'b0;
      end
      @(negedge clk) en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(brk_done === 1'b0 && txd === 1'b1, "R8", "done cleared by disable",
            int'({brk_done, txd}), 1);
      en = 1'b1;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_char(8, 1'b0, 1'b0, 1'b0, 14'h00A5, "R3");
      t_char(7, 1'b1, 1'b0, 1'b1, 14'h0035, "R3");
      t_char(5, 1'b1, 1'b1, 1'b0, 14'h0016, "R3");
      t_char(14, 1'b1, 1'b0, 1'b1, 14'h2C3A, "R3");
      // R4: lengths clamped at both ends, upper data bits ignored
      t_char(2, 1'b0, 1'b0, 1'b0, 14'h3FEA, "R4");
      t_char(15, 1'b1, 1'b1, 1'b0, 14'h1357, "R4");
      t_b2b();
      t_break(8, 1'b0, 1'b0, 3, 1'b1);
      t_break(8, 1'b0, 1'b0, 0, 1'b0);
      t_break(5, 1'b0, 1'b0, 2, 1'b0);
      t_break(14, 1'b1, 1'b1, 1, 1'b0);
      // R8: resumes after re-enable
      t_char(8, 1'b1, 1'b1, 1'b0, 14'h00C3, "R8");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog (all requirements): run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule